// File: doc/BRIEF.md
# Private Countdown Timer

A 32-bit down-counting timer for one processor core, programmed through four word registers on a simple write/read bus. Software sets a reload value, can overwrite the live count at any time, and picks through a control word whether the timer runs once or reloads itself, whether expiry raises an interrupt, and how many input ticks make up one count step. Each expiry sets a sticky flag. The flag drives a level interrupt whenever the interrupt enable is on, and software clears it by writing a one.

The block reacts to bus writes that hit a running counter. Writing zero to the reload value or to the count can stop the timer without raising the flag. Changing the mode bits stops the counter before the new control word takes effect. A periodic timer whose count has reached zero is refilled from the reload value when it is switched on. Several of these rules apply only when the prescaler is zero.

Top module: `pcore_timer`

## Requirements
- R1: After reset, every register reads zero, irq is low, and the counter does not move on input ticks.
- R2: The byte offsets are 0x0 reload, 0x4 live count, 0x8 control and 0xC status. Any other offset reads zero, and writes to it change nothing. Control reads back only bit 0 (enable), bit 1 (periodic), bit 2 (interrupt enable) and bits 15:8 (prescaler); every other bit reads zero.
- R3: While running, the count drops by one every (prescaler + 1) input ticks. While stopped, ticks leave it unchanged.
- R4: When a count step finds the count at 1 or 0, the status flag (bit 0 at 0xC) is set. A one-shot timer then stops with a count of zero. A periodic timer reloads the count from the reload register.
- R5: irq is high exactly when the status flag and the interrupt enable are both set, and it follows a change of either in the next cycle.
- R6: Writing the status register clears the flag when data bit 0 is 1. Writing a zero there leaves the flag unchanged.
- R7: A periodic timer with a reload value of zero and a prescaler of zero stops on expiry. With a non-zero prescaler it expires again on every step.
- R8: A reload write also loads the count. If the timer is enabled, it then runs when the prescaler or the written value is non-zero, and stops without setting the flag otherwise.
- R9: With the timer enabled and the prescaler at zero, writing zero to the count stops a one-shot timer, or a periodic timer whose reload is zero, without setting the flag. A periodic timer with a non-zero reload takes the reload value instead and keeps running.
- R10: A control write that changes bits 1:0 stops the counter. If the new word enables the timer, it restarts when the prescaler or the count is non-zero. When the new word enables periodic mode with a zero prescaler while the count is zero, the count is first refilled from the reload register.
- R11: Any write to the reload, count or control register restarts the prescaler phase, so the next count step comes a full (prescaler + 1) ticks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Input tick enable, one count pulse per cycle while high |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte address; the low two bits are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The assertions take it that tick is a one-cycle qualifier, and that a write cycle to the reload, count or control register carries no counting. The expiry and reload properties are therefore gated on the absence of such a write. The bench keeps tick low during every bus write, so each step in the bench comes from ticks alone. It places every write between whole tick bursts, so the expected count is always a plain function of the number of ticks applied since the last write.

// File: rtl/pcore_timer.sv
module pcore_timer #(
  parameter int DATA_W = 32,
  parameter int PRE_W  = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int EN_BIT  = 0;
  localparam int PER_BIT = 1;
  localparam int IE_BIT  = 2;
  localparam int PRE_LSB = 8;
  localparam logic [ADDR_W-3:0] W_LOAD = 0;
  localparam logic [ADDR_W-3:0] W_CNT  = 1;
  localparam logic [ADDR_W-3:0] W_CTRL = 2;
  localparam logic [ADDR_W-3:0] W_STAT = 3;
  localparam logic [DATA_W-1:0] ONE    = 1;

  logic [DATA_W-1:0] load_q, cnt_q;
  logic              en_q, per_q, ie_q, status_q, run_q;
  logic [PRE_W-1:0]  presc_q, pre_q;

  logic [ADDR_W-3:0] word;
  logic              unused_lsb;
  assign word       = bus_addr[ADDR_W-1:2];
  assign unused_lsb = ^bus_addr[1:0];

  logic sel_load, sel_cnt, sel_ctrl, sel_stat;
  assign sel_load = bus_wr && word == W_LOAD;
  assign sel_cnt  = bus_wr && word == W_CNT;
  assign sel_ctrl = bus_wr && word == W_CTRL;
  assign sel_stat = bus_wr && word == W_STAT;

  logic             w_en, w_per, w_ie;
  logic [PRE_W-1:0] w_presc;
  assign w_en    = bus_wdata[EN_BIT];
  assign w_per   = bus_wdata[PER_BIT];
  assign w_ie    = bus_wdata[IE_BIT];
  assign w_presc = bus_wdata[PRE_LSB +: PRE_W];

  logic presc_zero, wdata_zero;
  assign presc_zero = presc_q == '0;
  assign wdata_zero = bus_wdata == '0;

  logic [DATA_W-1:0] cnt_wr_val, ctl_cnt;
  assign cnt_wr_val = (en_q && per_q && presc_zero && wdata_zero) ? load_q : bus_wdata;
  assign ctl_cnt    = (w_en && w_per && w_presc == '0 && cnt_q == '0) ? load_q : cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q   <= '0;
      cnt_q    <= '0;
      en_q     <= 1'b0;
      per_q    <= 1'b0;
      ie_q     <= 1'b0;
      presc_q  <= '0;
      pre_q    <= '0;
      status_q <= 1'b0;
      run_q    <= 1'b0;
    end else begin
      if (sel_stat && bus_wdata[0]) status_q <= 1'b0;
      if (sel_load) begin
        load_q <= bus_wdata;
        cnt_q  <= bus_wdata;
        pre_q  <= '0;
        if (en_q) run_q <= !presc_zero || !wdata_zero;
      end else if (sel_cnt) begin
        cnt_q <= cnt_wr_val;
        pre_q <= '0;
        if (en_q) run_q <= !presc_zero || cnt_wr_val != '0;
      end else if (sel_ctrl) begin
        en_q    <= w_en;
        per_q   <= w_per;
        ie_q    <= w_ie;
        presc_q <= w_presc;
        pre_q   <= '0;
        cnt_q   <= ctl_cnt;
        run_q   <= w_en && (w_presc != '0 || ctl_cnt != '0);
      end else if (run_q && tick) begin
        if (pre_q != presc_q) begin
          pre_q <= pre_q + 1'b1;
        end else begin
          pre_q <= '0;
          if (cnt_q > ONE) begin
            cnt_q <= cnt_q - ONE;
          end else begin
            status_q <= 1'b1;
            if (per_q) begin
              cnt_q <= load_q;
              if (load_q == '0 && presc_zero) run_q <= 1'b0;
            end else begin
              cnt_q <= '0;
              run_q <= 1'b0;
            end
          end
        end
      end
    end
  end

  logic [DATA_W-1:0] ctrl_rd, stat_rd;
  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[EN_BIT]  = en_q;
    ctrl_rd[PER_BIT] = per_q;
    ctrl_rd[IE_BIT]  = ie_q;
    ctrl_rd[PRE_LSB +: PRE_W] = presc_q;
    stat_rd = '0;
    stat_rd[0] = status_q;
  end

  always_comb begin
    case (word)
      W_LOAD:  bus_rdata = load_q;
      W_CNT:   bus_rdata = cnt_q;
      W_CTRL:  bus_rdata = ctrl_rd;
      W_STAT:  bus_rdata = stat_rd;
      default: bus_rdata = '0;
    endcase
  end

  assign irq = status_q & ie_q;
endmodule

// File: rtl/pcore_timer_checks.sv
module pcore_timer_checks #(
  parameter int DATA_W = 32,
  parameter int PRE_W  = 8,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              irq,
  input logic [DATA_W-1:0] load_q,
  input logic [DATA_W-1:0] cnt_q,
  input logic              en_q,
  input logic              per_q,
  input logic [PRE_W-1:0]  presc_q,
  input logic [PRE_W-1:0]  pre_q,
  input logic              status_q,
  input logic              run_q
);
  localparam logic [DATA_W-1:0] ONE = 1;
  localparam logic [ADDR_W-3:0] W_CTRL = 2;
  localparam logic [ADDR_W-3:0] W_STAT = 3;

  logic [ADDR_W-3:0] word;
  logic              blk, step, expire, unused_lsb;
  assign word       = bus_addr[ADDR_W-1:2];
  assign unused_lsb = ^bus_addr[1:0];
  assign blk        = bus_wr && word <= W_CTRL;
  assign step       = run_q && tick && pre_q == presc_q && !blk;
  assign expire     = step && cnt_q <= ONE;

  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> pre_q <= presc_q); // R3

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !bus_wr) |=> $stable(cnt_q)); // R3

  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !per_q) |=> (!run_q && cnt_q == '0 && status_q)); // R4

  AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && per_q) |=> (status_q && cnt_q == $past(load_q))); // R4

  AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && word == W_STAT && bus_wdata[0] && !expire) |=> !irq); // R6

  AST_ZERO_RELOAD_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && per_q && load_q == '0 && presc_q == '0) |=> !run_q); // R7

  AST_ZERO_LOAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && word == '0 && bus_wdata == '0 && en_q && presc_q == '0)
      |=> (!run_q && $stable(status_q))); // R8

  AST_RUN_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> en_q); // R10
endmodule

bind pcore_timer pcore_timer_checks #(.DATA_W(DATA_W), .PRE_W(PRE_W), .ADDR_W(ADDR_W)) u_checks (.*);

// File: tb/pcore_timer_bench.sv
module pcore_timer_bench;
  localparam int CLK_P = 10;
  localparam logic [4:0] A_LOAD = 5'h00, A_CNT = 5'h04, A_CTRL = 5'h08, A_STAT = 5'h0C;
  localparam logic [31:0] EN = 32'h1, PER = 32'h2, IE = 32'h4;
  // {prescaler, start count}
  localparam logic [39:0] VEC [0:5] = '{
    40'h00_00000001, 40'h00_00000005, 40'h01_00000003,
    40'h03_00000002, 40'h07_00000001, 40'h02_00000004};

  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        irq;
  int nchk = 0, nerr = 0;

  always #(CLK_P/2) clk = ~clk;

  pcore_timer u_pcore_timer (.clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic expect_reg(input string req, input logic [4:0] a, input logic [31:0] e);
    @(negedge clk); bus_addr = a; #1;
    chk(req, bus_rdata, e);
  endtask

  task automatic expect_irq(input string req, input logic e);
    @(negedge clk); #1;
    chk(req, {31'b0, irq}, {31'b0, e});
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin @(negedge clk); tick = 1'b1; end
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic cleanup;
    wr(A_CTRL, 32'h0);
    wr(A_STAT, 32'h1);
  endtask

  initial begin
    #(CLK_P * 150000);
    nchk++; nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    expect_reg("R1 load", A_LOAD, 0);
    expect_reg("R1 count", A_CNT, 0);
    expect_reg("R1 ctrl", A_CTRL, 0);
    expect_reg("R1 status", A_STAT, 0);
    expect_irq("R1 irq", 1'b0);
    ticks(4);
    expect_reg("R1 idle count", A_CNT, 0);

    // R2 map and control field positions
    wr(A_LOAD, 32'h1234_5678);
    expect_reg("R2 load", A_LOAD, 32'h1234_5678);
    expect_reg("R2 count follows load", A_CNT, 32'h1234_5678);
    expect_reg("R2 other offset", 5'h14, 0);
    wr(5'h18, 32'hDEAD_BEEF);
    expect_reg("R2 other write ignored", A_LOAD, 32'h1234_5678);
    wr(A_CTRL, 32'hFFFF_FF08);
    expect_reg("R2 ctrl fields", A_CTRL, 32'h0000_FF00);
    ticks(3);
    expect_reg("R3 stopped holds", A_CNT, 32'h1234_5678);

    // R3/R4 vector table: one-shot with interrupt
    for (int i = 0; i < 6; i++) begin
      int p, n, t;
      p = int'(VEC[i][39:32]);
      n = int'(VEC[i][31:0]);
      t = n * (p + 1) - 1;
      cleanup();
      wr(A_LOAD, 32'(n));
      wr(A_CTRL, EN | IE | (32'(p) << 8));
      ticks(t);
      expect_reg("R3 count before expiry", A_CNT, 32'(n - t / (p + 1)));
      expect_reg("R4 no flag before expiry", A_STAT, 0);
      ticks(1);
      expect_reg("R4 flag at expiry", A_STAT, 1);
      expect_irq("R5 irq at expiry", 1'b1);
      expect_reg("R4 one-shot count zero", A_CNT, 0);
      ticks(p + 1);
      expect_reg("R4 one-shot stays stopped", A_CNT, 0);
    end

    // R4 periodic reload
    cleanup();
    wr(A_LOAD, 3);
    wr(A_CTRL, EN | PER);
    ticks(3);
    expect_reg("R4 periodic flag", A_STAT, 1);
    expect_reg("R4 periodic reload", A_CNT, 3);
    ticks(1);
    expect_reg("R4 periodic keeps running", A_CNT, 2);

    // R5/R6 interrupt gating and write-one-to-clear
    cleanup();
    wr(A_LOAD, 2);
    wr(A_CTRL, EN);
    ticks(2);
    expect_reg("R5 flag set", A_STAT, 1);
    expect_irq("R5 irq masked", 1'b0);
    wr(A_CTRL, EN | IE);
    expect_irq("R5 irq after enable", 1'b1);
    wr(A_STAT, 0);
    expect_irq("R6 zero write keeps flag", 1'b1);
    wr(A_STAT, 1);
    expect_irq("R6 irq cleared", 1'b0);
    expect_reg("R6 flag cleared", A_STAT, 0);

    // R7 periodic with zero reload
    cleanup();
    wr(A_LOAD, 0);
    wr(A_CNT, 1);
    wr(A_CTRL, EN | PER);
    ticks(1);
    expect_reg("R7 expiry flag", A_STAT, 1);
    wr(A_STAT, 1);
    ticks(3);
    expect_reg("R7 stopped no refire", A_STAT, 0);
    cleanup();
    wr(A_LOAD, 0);
    wr(A_CNT, 1);
    wr(A_CTRL, EN | PER | 32'h100);
    ticks(2);
    expect_reg("R7 prescaled first expiry", A_STAT, 1);
    wr(A_STAT, 1);
    ticks(2);
    expect_reg("R7 prescaled refires", A_STAT, 1);

    // R8 zero reload writes
    cleanup();
    wr(A_LOAD, 5);
    wr(A_CTRL, EN);
    ticks(2);
    expect_reg("R8 running", A_CNT, 3);
    wr(A_LOAD, 0);
    ticks(4);
    expect_reg("R8 zero load count", A_CNT, 0);
    expect_reg("R8 zero load no flag", A_STAT, 0);
    cleanup();
    wr(A_LOAD, 7);
    wr(A_CTRL, EN | 32'h200);
    wr(A_LOAD, 0);
    ticks(2);
    expect_reg("R8 prescaled zero load waits", A_STAT, 0);
    ticks(1);
    expect_reg("R8 prescaled zero load expires", A_STAT, 1);

    // R9 zero count writes
    cleanup();
    wr(A_LOAD, 9);
    wr(A_CTRL, EN);
    ticks(1);
    wr(A_CNT, 0);
    ticks(3);
    expect_reg("R9 one-shot zero count", A_CNT, 0);
    expect_reg("R9 one-shot no flag", A_STAT, 0);
    cleanup();
    wr(A_LOAD, 4);
    wr(A_CTRL, EN | PER);
    ticks(2);
    wr(A_CNT, 0);
    expect_reg("R9 periodic takes reload", A_CNT, 4);
    ticks(1);
    expect_reg("R9 periodic keeps running", A_CNT, 3);
    wr(A_LOAD, 0);
    wr(A_CNT, 0);
    ticks(3);
    expect_reg("R9 periodic zero reload no flag", A_STAT, 0);

    // R10 control writes
    cleanup();
    wr(A_LOAD, 6);
    wr(A_CTRL, EN);
    ticks(2);
    wr(A_CTRL, 0);
    ticks(3);
    expect_reg("R10 disable stops", A_CNT, 4);
    wr(A_CTRL, EN);
    ticks(1);
    expect_reg("R10 resume", A_CNT, 3);
    cleanup();
    wr(A_LOAD, 2);
    wr(A_CTRL, EN);
    ticks(2);
    wr(A_CTRL, EN | PER);
    expect_reg("R10 periodic refill", A_CNT, 2);
    ticks(1);
    expect_reg("R10 refill runs", A_CNT, 1);
    cleanup();
    wr(A_LOAD, 2);
    wr(A_CTRL, EN);
    ticks(2);
    wr(A_CTRL, EN | PER | 32'h100);
    expect_reg("R10 no refill with prescaler", A_CNT, 0);
    ticks(2);
    expect_reg("R10 prescaled zero count expires", A_CNT, 2);

    // R11 prescaler phase restart
    cleanup();
    wr(A_LOAD, 10);
    wr(A_CTRL, EN | 32'h300);
    ticks(2);
    wr(A_CTRL, EN | 32'h300);
    ticks(3);
    expect_reg("R11 phase restarted", A_CNT, 10);
    ticks(1);
    expect_reg("R11 full period step", A_CNT, 9);

    // R1 reset while running
    wr(A_STAT, 1);
    wr(A_CTRL, EN | IE);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    expect_reg("R1 reset load", A_LOAD, 0);
    expect_reg("R1 reset ctrl", A_CTRL, 0);
    ticks(3);
    expect_reg("R1 reset count", A_CNT, 0);
    expect_irq("R1 reset irq", 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule